// File: doc/BRIEF.md
# SMBus Clock-Low Timeout Detector

This block sits beside a two-wire serial slave and guards it against a host that stalls with the clock line held low. It takes an already synchronised and filtered SCL level plus single-cycle START and STOP strobes from the bus front end. It measures how long SCL stays low on a free-running system clock. If the low phase inside an open transaction reaches a threshold, the detector emits a one-cycle reset pulse for the slave interface. It also asserts a level that forces the slave's SDA driver to let go of the line.

Counting happens only while a transaction is open, meaning after a START and before the next STOP, so an idle bus with SCL low never triggers. The threshold `TIMEOUT_CYC` is given in system clock cycles. It should be chosen so that the firing point lies above the guaranteed no-reset floor of 25 ms and below the guaranteed reset ceiling of 35 ms. For example, 30 ms at the system clock rate gives margin on both sides. After firing, the detector stays in a timed-out state, with SDA released, until the next START opens a fresh transaction.

Top module: `scl_timeout_mon`

## Requirements
- R1: During and right after synchronous reset, `bus_rst_o` and `sda_release_o` are 0 and no transaction is considered open.
- R2: While no transaction is open, SCL held low for any length of time produces no reset pulse and no release.
- R3: In an open transaction, when `scl_i` is sampled low on `TIMEOUT_CYC` consecutive clock edges without a START or STOP strobe, `bus_rst_o` is 1 for exactly the one cycle following the last of those edges.
- R4: A low run shorter than `TIMEOUT_CYC` samples, ended by SCL high, fires nothing, and the next low run is measured from zero.
- R5: A STOP strobe closes the transaction; SCL staying low afterwards fires nothing.
- R6: A START strobe inside an open transaction (repeated START) restarts the measurement from zero, so firing needs `TIMEOUT_CYC` further low samples after the strobe's edge.
- R7: `sda_release_o` rises in the same cycle as the reset pulse and stays 1. Only one reset pulse is issued per timeout, even if SCL remains low.
- R8: While timed out, a STOP strobe has no effect. A START strobe clears `sda_release_o` from the following cycle and opens a transaction measured from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised, filtered SCL level |
| start_evt_i | input | 1 | One-cycle strobe: START or repeated START seen |
| stop_evt_i | input | 1 | One-cycle strobe: STOP seen |
| bus_rst_o | output | 1 | One-cycle reset pulse for the slave interface |
| sda_release_o | output | 1 | Forces the slave's SDA driver off while timed out |

## Verification
The bound checker watches four things on every cycle. The reset pulse lasts a single cycle and never arrives before SCL has been low without a strobe for the full threshold. The release level rises only together with a pulse, and once high it drops only after a START. The bench's scenarios are needed for the behaviours that depend on transaction context. These are the exact firing cycle, the silence of an idle bus, short runs one sample under the limit, a STOP closing the window, the restart on a repeated START, and the fresh count after recovery. The bench checks them against expected cycle numbers and against total pulse counts.

// File: rtl/sclto_pkg.sv
package sclto_pkg;
  typedef enum logic [1:0] {
    WIN_IDLE    = 2'd0,
    WIN_OPEN    = 2'd1,
    WIN_EXPIRED = 2'd2
  } win_state_e;
endpackage

// File: rtl/sclto_lowcnt.sv
// Low-phase counter: counts consecutive enabled cycles and flags the last one.
module sclto_lowcnt #(
  parameter int LIMIT = 3_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic count_en,
  output logic expire
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt;

  assign expire = count_en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !count_en) begin
      cnt <= '0;
    end else if (cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sclto_window.sv
// Transaction window tracker and timeout outputs.
module sclto_window
  import sclto_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic       expire,
  output win_state_e state_o,
  output logic       rst_pulse_o,
  output logic       release_o
);
  win_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WIN_IDLE: begin
        if (start_evt) state_d = WIN_OPEN;
      end
      WIN_OPEN: begin
        if (start_evt)     state_d = WIN_OPEN;
        else if (stop_evt) state_d = WIN_IDLE;
        else if (expire)   state_d = WIN_EXPIRED;
      end
      WIN_EXPIRED: begin
        if (start_evt) state_d = WIN_OPEN;
      end
      default: state_d = WIN_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= WIN_IDLE;
      rst_pulse_o <= 1'b0;
      release_o   <= 1'b0;
    end else begin
      state_q     <= state_d;
      rst_pulse_o <= (state_q == WIN_OPEN) && (state_d == WIN_EXPIRED);
      release_o   <= (state_d == WIN_EXPIRED);
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/scl_timeout_mon.sv
module scl_timeout_mon
  import sclto_pkg::*;
#(
  parameter int TIMEOUT_CYC = 3_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic start_evt_i,
  input  logic stop_evt_i,
  output logic bus_rst_o,
  output logic sda_release_o
);
  win_state_e win_state;
  logic       count_en;
  logic       expire;

  assign count_en = (win_state == WIN_OPEN) && !scl_i && !start_evt_i && !stop_evt_i;

  sclto_lowcnt #(.LIMIT(TIMEOUT_CYC)) u_lowcnt (
    .clk      (clk),
    .rst      (rst),
    .count_en (count_en),
    .expire   (expire)
  );

  sclto_window u_window (
    .clk         (clk),
    .rst         (rst),
    .start_evt   (start_evt_i),
    .stop_evt    (stop_evt_i),
    .expire      (expire),
    .state_o     (win_state),
    .rst_pulse_o (bus_rst_o),
    .release_o   (sda_release_o)
  );
endmodule

// File: rtl/sclto_chk.sv
module sclto_chk #(
  parameter int LIMIT = 3_000_000
) (
  input logic clk,
  input logic rst,
  input logic scl_i,
  input logic start_evt_i,
  input logic stop_evt_i,
  input logic bus_rst_o,
  input logic sda_release_o
);
  localparam int RUN_W = $clog2(LIMIT + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(LIMIT);

  logic [RUN_W-1:0] low_run;

  always_ff @(posedge clk) begin
    if (rst || scl_i || start_evt_i || stop_evt_i) low_run <= '0;
    else if (low_run != RUN_MAX)                   low_run <= low_run + 1'b1;
  end

  // R3
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rst_o |=> !bus_rst_o);

  // R4
  pulse_after_full_run_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rst_o |-> (low_run == RUN_MAX));

  // R7
  release_rise_with_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_release_o) |-> bus_rst_o);

  // R7
  pulse_implies_release_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rst_o |-> sda_release_o);

  // R8
  release_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_release_o && !start_evt_i) |=> sda_release_o);
endmodule

bind scl_timeout_mon sclto_chk #(.LIMIT(TIMEOUT_CYC)) u_sclto_chk (
  .clk           (clk),
  .rst           (rst),
  .scl_i         (scl_i),
  .start_evt_i   (start_evt_i),
  .stop_evt_i    (stop_evt_i),
  .bus_rst_o     (bus_rst_o),
  .sda_release_o (sda_release_o)
);

// File: tb/tb_scl_timeout_mon.sv
module tb_scl_timeout_mon;
  localparam int LIM = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sta = 1'b0;
  logic sto = 1'b0;
  logic bus_rst, sda_rel;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int pulses = 0;
  bit done = 1'b0;

  typedef struct {
    int    at;
    bit    e_rst;
    bit    e_rel;
    string tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  scl_timeout_mon #(.TIMEOUT_CYC(LIM)) dut (
    .clk(clk), .rst(rst), .scl_i(scl), .start_evt_i(sta), .stop_evt_i(sto),
    .bus_rst_o(bus_rst), .sda_release_o(sda_rel)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: samples 2 ns after each edge, pops due expectations.
  always @(posedge clk) begin
    #2;
    if (bus_rst && !rst) pulses++;
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (e.at != cyc || bus_rst != e.e_rst || sda_rel != e.e_rel) begin
        n_fail++;
        $display("FAIL %s cyc=%0d/%0d actual rst=%0b rel=%0b expected rst=%0b rel=%0b",
                 e.tag, cyc, e.at, bus_rst, sda_rel, e.e_rst, e.e_rel);
      end
    end
  end

  task automatic expect_at(int ofs, bit r, bit l, string tag);
    exp_t e;
    e.at = cyc + ofs; e.e_rst = r; e.e_rel = l; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic tick(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic strobe_start();
    sta = 1'b1; tick(1); sta = 1'b0;
  endtask

  task automatic strobe_stop();
    sto = 1'b1; tick(1); sto = 1'b0;
  endtask

  task automatic check_pulses(int exp_n, string tag);
    tick(2);
    n_chk++;
    if (pulses != exp_n) begin
      n_fail++;
      $display("FAIL %s pulse count actual %0d expected %0d", tag, pulses, exp_n);
    end
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    expect_at(1, 0, 0, "R1");
    tick(3);

    // R2: idle bus, SCL low for a long time
    scl = 1'b0;
    expect_at(3 * LIM, 0, 0, "R2");
    tick(3 * LIM + 2);
    check_pulses(0, "R2");

    // R3 / R7: open transaction, stall SCL low
    scl = 1'b1;
    strobe_start();
    scl = 1'b0;
    expect_at(LIM - 1, 0, 0, "R3 before limit");
    expect_at(LIM, 1, 1, "R3 fire");
    expect_at(LIM + 1, 0, 1, "R7 release held");
    expect_at(3 * LIM, 0, 1, "R7 still released");
    tick(3 * LIM + 2);
    check_pulses(1, "R7 single pulse");

    // R8: STOP while timed out ignored; START recovers
    strobe_stop();
    expect_at(2, 0, 1, "R8 stop ignored");
    tick(3);
    scl = 1'b1;
    expect_at(1, 0, 0, "R8 start clears release");
    strobe_start();
    // R4: two runs one short of limit
    scl = 1'b0; tick(LIM - 1); scl = 1'b1; tick(2);
    scl = 1'b0; tick(LIM - 1); scl = 1'b1; tick(2);
    check_pulses(1, "R4 short runs");
    // R8: fresh count after recovery fires normally
    scl = 1'b0;
    expect_at(LIM - 1, 0, 0, "R8 fresh before");
    expect_at(LIM, 1, 1, "R8 fresh fire");
    tick(LIM + 3);
    check_pulses(2, "R8 fresh pulse");

    // R5: STOP closes the window
    scl = 1'b1;
    strobe_start();
    scl = 1'b0; tick(10);
    strobe_stop();
    expect_at(3 * LIM, 0, 0, "R5 closed");
    tick(3 * LIM + 2);
    check_pulses(2, "R5 no pulse");

    // R6: repeated START restarts the count
    scl = 1'b1;
    strobe_start();
    scl = 1'b0; tick(15);
    expect_at(LIM, 0, 0, "R6 restarted");
    expect_at(LIM + 1, 1, 1, "R6 fire");
    strobe_start();
    tick(LIM + 3);
    check_pulses(3, "R6 pulse");

    tick(3);
    n_chk++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard pending actual %0d expected 0", q.size());
    end
    done = 1'b1;
  end

  initial begin
    int w;
    w = 0;
    while (!done && w < 20000) begin
      @(posedge clk);
      w++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule